// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the control pins of a synchronous DRAM interface and turns every sampled clock edge into a named command. It follows the state of each of the four banks through opening, open, closing, refresh and mode-set lockout. Any command that the current bank state does not allow raises a one-cycle violation strobe. It suits a memory controller's protocol monitor, or a model that has to flag protocol errors as they happen.

An edge is a valid command edge only when the clock-enable sampled on the previous edge (`cke_prev`) was high. Edges that are not valid decode to no command and leave every bank and timer frozen. The opening, closing, refresh and mode-set windows are parameters counted in valid clock edges. Each must be at least 2.

The command code, bank, auto-precharge flag and violation strobe are registered. They show the command sampled at the most recent rising edge, and the bank states already include its effect. Auto-precharge reads and writes close their bank as soon as they are accepted. Burst length is not modelled.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: A valid edge with `cs_n` high decodes to deselect. With `cs_n` low, the pattern `ras_n,cas_n,we_n` decodes as follows: 111 no-op, 110 burst stop, 101 read, 100 write, 011 activate, 010 precharge (all banks when `a10` is high), 001 refresh (self refresh when `cke` is low), 000 mode set. `cmd_code` values are: 0 none, 1 deselect, 2 no-op, 3 burst stop, 4 read, 5 write, 6 activate, 7 precharge one bank, 8 precharge all, 9 refresh, 10 self refresh, 11 mode set. The code appears in the cycle after the sampling edge.
- R2: On an edge where `cke_prev` is low, `cmd_code` is 0 and `illegal` is 0, whatever the other pins are. No bank state changes and no timer advances on that edge.
- R3: `cmd_bank` repeats `ba`, where 0..3 select banks A..D. `auto_pre` is `a10` for reads and writes and 0 for all other commands. Bank i's state sits at `bank_state[3i+2:3i]`, encoded as 0 idle, 1 opening, 2 open, 3 closing, 4 refreshing, 5 mode-set lockout.
- R4: An activate to an idle bank puts it in opening. It becomes open T_RCD valid edges after the activate, so a read issued T_RCD edges after the activate is legal.
- R5: A read or write is legal only to an open bank. With `a10` high, an accepted read or write moves its bank to closing.
- R6: A single-bank precharge is legal to an idle, open or closing bank, and only an open bank changes (to closing). A closing bank becomes idle T_RP valid edges after it entered closing. An activate to it before then is illegal.
- R7: Precharge-all is legal unless some bank is opening, refreshing or in mode-set lockout. It moves every open bank to closing.
- R8: Refresh and self refresh are legal only when all banks are idle. They put every bank in refreshing for T_RC valid edges, and any command other than deselect, no-op or burst stop is illegal during that window.
- R9: Mode set is legal only when all banks are idle. It puts every bank in mode-set lockout for T_RSC valid edges, and other commands are illegal during that window.
- R10: An illegal command raises `illegal` for exactly the one cycle that shows it, and does not change any bank state. Timers already running keep counting.
- R11: A synchronous reset makes every bank idle, clears every timer, and sets `cmd_code`, `cmd_bank`, `auto_pre` and `illegal` to 0.
- R12: Deselect, no-op and burst stop are never flagged illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge samples the pins |
| rst | input | 1 | Synchronous reset, active high |
| cke_prev | input | 1 | Clock enable sampled on the previous edge; high marks a valid edge |
| cke | input | 1 | Clock enable at this edge; low with refresh pattern selects self refresh |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select bit |
| addr_rest | input | 11 | Remaining address bits (not decoded) |
| cmd_code | output | 4 | Decoded command of the last edge |
| cmd_bank | output | 2 | Bank address of the last edge |
| auto_pre | output | 1 | Auto-precharge requested by last read/write |
| bank_state | output | 12 | Three-bit state per bank |
| illegal | output | 1 | One-cycle protocol violation strobe |

## Verification
Some properties are checked on every cycle: the allowed state-to-state moves of each bank, the freeze on edges that are not valid, the strobe never firing for deselect, no-op or burst stop, and every bank refreshing after an accepted refresh. Only the bench's scenarios can show the exact edge on which each timed window closes, the legality verdict for a given command in a given state, that an illegal command leaves the state untouched, and the combined effect of precharge-all on a mix of open and idle banks.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [3:0] {
    CMD_NONE  = 4'd0,
    CMD_DESL  = 4'd1,
    CMD_NOP   = 4'd2,
    CMD_BST   = 4'd3,
    CMD_READ  = 4'd4,
    CMD_WRITE = 4'd5,
    CMD_ACT   = 4'd6,
    CMD_PRE   = 4'd7,
    CMD_PALL  = 4'd8,
    CMD_REF   = 4'd9,
    CMD_SELF  = 4'd10,
    CMD_MRS   = 4'd11
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE    = 3'd0,
    BK_OPENING = 3'd1,
    BK_OPEN    = 3'd2,
    BK_CLOSING = 3'd3,
    BK_REFRESH = 3'd4,
    BK_MODESET = 3'd5
  } bank_e;

  localparam int STATE_W = 3;

  // Map one sampled pin set to a command.
  function automatic cmd_e decode_pins(input logic valid, input logic cke,
                                       input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n,
                                       input logic a10);
    cmd_e c;
    if (!valid)     c = CMD_NONE;
    else if (cs_n)  c = CMD_DESL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = CMD_NOP;
        3'b110:  c = CMD_BST;
        3'b101:  c = CMD_READ;
        3'b100:  c = CMD_WRITE;
        3'b011:  c = CMD_ACT;
        3'b010:  c = a10 ? CMD_PALL : CMD_PRE;
        3'b001:  c = cke ? CMD_REF : CMD_SELF;
        default: c = CMD_MRS;
      endcase
    end
    return c;
  endfunction

  // A window of t valid edges ends on the (t-1)th edge after entry.
  function automatic int window_reload(input int t);
    return t - 1;
  endfunction

  function automatic logic is_timed(input bank_e s);
    return (s == BK_OPENING) || (s == BK_CLOSING) ||
           (s == BK_REFRESH) || (s == BK_MODESET);
  endfunction

  function automatic logic is_blocking(input bank_e s);
    return (s == BK_OPENING) || (s == BK_REFRESH) || (s == BK_MODESET);
  endfunction

endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
  import sdc_pkg::*;
(
  input  logic valid_i,
  input  logic cke_i,
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  input  logic a10_i,
  output cmd_e cmd_o,
  output logic ap_o
);
  always_comb begin
    cmd_o = decode_pins(valid_i, cke_i, cs_n_i, ras_n_i, cas_n_i, we_n_i, a10_i);
    ap_o  = a10_i && ((cmd_o == CMD_READ) || (cmd_o == CMD_WRITE));
  end
endmodule

// File: rtl/sdc_rules.sv
module sdc_rules
  import sdc_pkg::*;
#(
  parameter int BANK_W = 2,
  localparam int NBANK = 1 << BANK_W
) (
  input  cmd_e                       cmd_i,
  input  logic [BANK_W-1:0]          bank_i,
  input  logic [NBANK*STATE_W-1:0]   states_i,
  output logic                       legal_o
);
  bank_e st [NBANK];
  bank_e tgt;
  logic  all_idle;
  logic  any_block;

  always_comb begin
    all_idle  = 1'b1;
    any_block = 1'b0;
    for (int i = 0; i < NBANK; i++) begin
      st[i]     = bank_e'(states_i[i*STATE_W +: STATE_W]);
      all_idle  = all_idle && (st[i] == BK_IDLE);
      any_block = any_block || is_blocking(st[i]);
    end
    tgt = st[bank_i];
    case (cmd_i)
      CMD_READ, CMD_WRITE:     legal_o = (tgt == BK_OPEN);
      CMD_ACT:                 legal_o = (tgt == BK_IDLE);
      CMD_PRE:                 legal_o = (tgt == BK_IDLE) || (tgt == BK_OPEN) ||
                                         (tgt == BK_CLOSING);
      CMD_PALL:                legal_o = !any_block;
      CMD_REF, CMD_SELF,
      CMD_MRS:                 legal_o = all_idle;
      default:                 legal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank
  import sdc_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int BANK_ID = 0,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RC    = 6,
  parameter int T_RSC   = 2,
  parameter int CW      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ap_i,
  input  logic              legal_i,
  output bank_e             state_o
);
  bank_e          st;
  logic [CW-1:0]  cnt;
  logic           hit;
  logic           start;
  bank_e          start_st;
  logic [CW-1:0]  start_cnt;
  logic           win_done;

  assign hit      = legal_i && (bank_i == BANK_W'(BANK_ID));
  assign win_done = (cnt <= CW'(1));

  always_comb begin
    start     = 1'b0;
    start_st  = st;
    start_cnt = cnt;
    if (legal_i) begin
      case (cmd_i)
        CMD_ACT: if (hit) begin
          start = 1'b1; start_st = BK_OPENING; start_cnt = CW'(window_reload(T_RCD));
        end
        CMD_READ, CMD_WRITE: if (hit && ap_i) begin
          start = 1'b1; start_st = BK_CLOSING; start_cnt = CW'(window_reload(T_RP));
        end
        CMD_PRE: if (hit && st == BK_OPEN) begin
          start = 1'b1; start_st = BK_CLOSING; start_cnt = CW'(window_reload(T_RP));
        end
        CMD_PALL: if (st == BK_OPEN) begin
          start = 1'b1; start_st = BK_CLOSING; start_cnt = CW'(window_reload(T_RP));
        end
        CMD_REF, CMD_SELF: begin
          start = 1'b1; start_st = BK_REFRESH; start_cnt = CW'(window_reload(T_RC));
        end
        CMD_MRS: begin
          start = 1'b1; start_st = BK_MODESET; start_cnt = CW'(window_reload(T_RSC));
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= BK_IDLE;
      cnt <= '0;
    end else if (en_i) begin
      if (start) begin
        st  <= start_st;
        cnt <= start_cnt;
      end else if (is_timed(st)) begin
        if (win_done) begin
          st  <= (st == BK_OPENING) ? BK_OPEN : BK_IDLE;
          cnt <= '0;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  assign state_o = st;

  AST_OPENING_GOES_OPEN: assert property (@(posedge clk) disable iff (rst)
    (st == BK_OPENING) |=> (st == BK_OPENING || st == BK_OPEN)); // R4
  AST_CLOSING_GOES_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == BK_CLOSING) |=> (st == BK_CLOSING || st == BK_IDLE)); // R6
  AST_MODESET_GOES_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == BK_MODESET) |=> (st == BK_MODESET || st == BK_IDLE)); // R9
  AST_HOLD_WITHOUT_CLOCK: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> ($stable(st) && $stable(cnt))); // R2
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdc_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int ADDR_REST_W = 11,
  parameter int T_RCD       = 3,
  parameter int T_RP        = 3,
  parameter int T_RC        = 6,
  parameter int T_RSC       = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cke_prev,
  input  logic                         cke,
  input  logic                         cs_n,
  input  logic                         ras_n,
  input  logic                         cas_n,
  input  logic                         we_n,
  input  logic [BANK_W-1:0]            ba,
  input  logic                         a10,
  input  logic [ADDR_REST_W-1:0]       addr_rest,
  output logic [3:0]                   cmd_code,
  output logic [BANK_W-1:0]            cmd_bank,
  output logic                         auto_pre,
  output logic [(1<<BANK_W)*3-1:0]     bank_state,
  output logic                         illegal
);
  localparam int NBANK  = 1 << BANK_W;
  localparam int T_MAX1 = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int T_MAX2 = (T_RC > T_RSC) ? T_RC : T_RSC;
  localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
  localparam int CW     = $clog2(T_MAX + 1);

  cmd_e  cmd_now;
  logic  ap_now;
  logic  legal_now;
  bank_e st [NBANK];
  logic [NBANK*STATE_W-1:0] st_flat;

  cmd_e              cmd_q;
  logic [BANK_W-1:0] bank_q;
  logic              ap_q;
  logic              illegal_q;

  logic unused_addr_bits;
  assign unused_addr_bits = ^addr_rest;

  sdc_decode u_dec (
    .valid_i (cke_prev),
    .cke_i   (cke),
    .cs_n_i  (cs_n),
    .ras_n_i (ras_n),
    .cas_n_i (cas_n),
    .we_n_i  (we_n),
    .a10_i   (a10),
    .cmd_o   (cmd_now),
    .ap_o    (ap_now)
  );

  sdc_rules #(.BANK_W(BANK_W)) u_rules (
    .cmd_i    (cmd_now),
    .bank_i   (ba),
    .states_i (st_flat),
    .legal_o  (legal_now)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sdc_bank #(
      .BANK_W (BANK_W), .BANK_ID(g), .T_RCD(T_RCD), .T_RP(T_RP),
      .T_RC   (T_RC),   .T_RSC (T_RSC), .CW(CW)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .en_i    (cke_prev),
      .cmd_i   (cmd_now),
      .bank_i  (ba),
      .ap_i    (ap_now),
      .legal_i (legal_now),
      .state_o (st[g])
    );
    assign st_flat[g*STATE_W +: STATE_W] = st[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= CMD_NONE;
      bank_q    <= '0;
      ap_q      <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      cmd_q     <= cmd_now;
      bank_q    <= ba;
      ap_q      <= ap_now;
      illegal_q <= !legal_now;
    end
  end

  assign cmd_code   = cmd_q;
  assign cmd_bank   = bank_q;
  assign auto_pre   = ap_q;
  assign illegal    = illegal_q;
  assign bank_state = st_flat;

  AST_QUIET_COMMANDS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> (cmd_q != CMD_NONE && cmd_q != CMD_DESL &&
                   cmd_q != CMD_NOP && cmd_q != CMD_BST)); // R12
  AST_REFRESH_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
    ((cmd_q == CMD_REF || cmd_q == CMD_SELF) && !illegal_q) |->
      (st[0] == BK_REFRESH && st[NBANK-1] == BK_REFRESH)); // R8
  AST_PLAIN_ACCESS_STAYS_OPEN: assert property (@(posedge clk) disable iff (rst)
    ((cmd_q == CMD_READ || cmd_q == CMD_WRITE) && !illegal_q && !ap_q) |->
      (st[bank_q] == BK_OPEN)); // R5
  AST_LEGAL_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_ACT && !illegal_q) |-> (st[bank_q] == BK_OPENING)); // R4
endmodule

// File: tb/tb_sdram_cmd_tracker.sv
module tb_sdram_cmd_tracker;
  logic        clk = 0;
  logic        rst = 1;
  logic        cke_prev = 1, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0]  ba = 0;
  logic        a10 = 0;
  logic [10:0] addr_rest = 0;
  logic [3:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic        auto_pre;
  logic [11:0] bank_state;
  logic        illegal;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_cmd_tracker dut (
    .clk(clk), .rst(rst), .cke_prev(cke_prev), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .addr_rest(addr_rest), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .auto_pre(auto_pre), .bank_state(bank_state), .illegal(illegal)
  );

  function automatic int bst(input int i);
    return int'(bank_state[3*i +: 3]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // pins: cs, ras/cas/we pattern, bank, a10
  task automatic issue(input bit c, input bit [2:0] rcw, input int b, input bit a);
    cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = 2'(b); a10 = a;
    addr_rest = 11'(b * 37 + 5);
    step();
    cs_n = 1; {ras_n, cas_n, we_n} = 3'b111;
  endtask

  task automatic nop();            issue(0, 3'b111, 0, 0); endtask
  task automatic act(input int b); issue(0, 3'b011, b, 0); endtask
  task automatic rd(input int b, input bit a); issue(0, 3'b101, b, a); endtask
  task automatic wr(input int b, input bit a); issue(0, 3'b100, b, a); endtask
  task automatic pre(input int b); issue(0, 3'b010, b, 0); endtask
  task automatic pall();           issue(0, 3'b010, 1, 1); endtask
  task automatic refr();           issue(0, 3'b001, 0, 0); endtask
  task automatic mrs();            issue(0, 3'b000, 0, 0); endtask

  task automatic all_state(input string req, input int s);
    for (int i = 0; i < 4; i++) chk(req, bst(i), s);
  endtask

  task automatic t_reset();
    rst = 1; step(); step();
    chk("R11 code", cmd_code, 0); chk("R11 illegal", illegal, 0);
    chk("R11 bank", cmd_bank, 0); chk("R11 ap", auto_pre, 0);
    rst = 0;
    all_state("R11 idle", 0);
    act(0);
    chk("R4 opening", bst(0), 1);
    rst = 1; step(); rst = 0;
    all_state("R11 reset clears bank", 0);
    chk("R11 code after reset", cmd_code, 0);
  endtask

  task automatic t_decode();
    issue(1, 3'b000, 3, 1);
    chk("R1 deselect", cmd_code, 1); chk("R12 deselect legal", illegal, 0);
    nop();
    chk("R1 nop", cmd_code, 2); chk("R12 nop legal", illegal, 0);
    issue(0, 3'b110, 0, 0);
    chk("R1 burst stop", cmd_code, 3); chk("R12 bst legal", illegal, 0);
    rd(2, 1);
    chk("R1 read", cmd_code, 4); chk("R3 bank", cmd_bank, 2);
    chk("R3 ap", auto_pre, 1); chk("R5 read idle illegal", illegal, 1);
    chk("R10 unchanged", bst(2), 0);
    nop();
    chk("R10 one cycle", illegal, 0);
    wr(3, 0);
    chk("R1 write", cmd_code, 5); chk("R5 write idle illegal", illegal, 1);
    chk("R3 ap off", auto_pre, 0); chk("R3 bank3", cmd_bank, 3);
  endtask

  task automatic t_act_access();
    act(1);
    chk("R1 act", cmd_code, 6); chk("R4 legal", illegal, 0); chk("R4 opening", bst(1), 1);
    rd(1, 0);
    chk("R4 read too early", illegal, 1); chk("R10 still opening", bst(1), 1);
    nop();
    chk("R4 open after tRCD", bst(1), 2);
    rd(1, 0);
    chk("R5 read legal", illegal, 0); chk("R5 stays open", bst(1), 2);
    act(1);
    chk("R10 act open illegal", illegal, 1); chk("R10 open kept", bst(1), 2);
    wr(1, 1);
    chk("R5 write ap legal", illegal, 0); chk("R3 ap set", auto_pre, 1);
    chk("R5 ap closes", bst(1), 3);
    act(1);
    chk("R6 act closing illegal", illegal, 1); chk("R6 still closing", bst(1), 3);
    nop();
    chk("R6 idle after tRP", bst(1), 0);
  endtask

  task automatic t_precharge();
    act(2);
    pre(2);
    chk("R6 pre opening illegal", illegal, 1); chk("R1 pre", cmd_code, 7);
    nop();
    chk("R4 open", bst(2), 2);
    pre(2);
    chk("R6 pre legal", illegal, 0); chk("R6 closing", bst(2), 3);
    chk("R6 other bank idle", bst(0), 0);
    pre(2);
    chk("R6 pre closing legal", illegal, 0); chk("R6 closing kept", bst(2), 3);
    nop();
    chk("R6 idle", bst(2), 0);
  endtask

  task automatic t_pall();
    act(0); act(3);
    pall();
    chk("R7 pall opening illegal", illegal, 1); chk("R1 pall code", cmd_code, 8);
    nop();
    chk("R4 bank0 open", bst(0), 2); chk("R4 bank3 open", bst(3), 2);
    refr();
    chk("R8 refresh busy illegal", illegal, 1); chk("R10 bank0 kept", bst(0), 2);
    mrs();
    chk("R9 mrs busy illegal", illegal, 1);
    pall();
    chk("R7 pall legal", illegal, 0);
    chk("R7 bank0 closing", bst(0), 3); chk("R7 bank3 closing", bst(3), 3);
    chk("R7 bank1 idle", bst(1), 0);
    nop(); nop();
    all_state("R7 all idle", 0);
  endtask

  task automatic t_refresh();
    refr();
    chk("R1 refresh", cmd_code, 9); chk("R8 legal", illegal, 0);
    all_state("R8 refreshing", 4);
    act(0);
    chk("R8 act locked out", illegal, 1);
    nop(); nop(); nop();
    chk("R8 still refreshing", bst(0), 4);
    nop();
    all_state("R8 idle after tRC", 0);
  endtask

  task automatic t_mrs();
    mrs();
    chk("R1 mrs", cmd_code, 11); chk("R9 legal", illegal, 0);
    all_state("R9 lockout", 5);
    act(0);
    chk("R9 act in lockout illegal", illegal, 1);
    all_state("R9 idle after tRSC", 0);
    mrs();
    chk("R9 mrs again legal", illegal, 0);
    nop();
    all_state("R9 idle", 0);
  endtask

  task automatic t_cke();
    cke = 0; refr(); // self refresh entry
    chk("R1 self refresh", cmd_code, 10); chk("R8 self legal", illegal, 0);
    all_state("R8 self refreshing", 4);
    cke_prev = 0;
    for (int i = 0; i < 6; i++) rd(1, 0);
    chk("R2 none code", cmd_code, 0); chk("R2 no strobe", illegal, 0);
    all_state("R2 frozen", 4);
    cke = 1; nop();
    chk("R2 exit edge frozen", bst(0), 4);
    cke_prev = 1;
    nop(); nop(); nop(); nop();
    chk("R2 timer resumed", bst(3), 4);
    nop();
    all_state("R8 idle after self", 0);
  endtask

  initial begin
    t_reset();
    t_decode();
    t_act_access();
    t_precharge();
    t_pall();
    t_refresh();
    t_mrs();
    t_cke();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule